// File: doc/BRIEF.md
# Measurement Conversion Sequencer

This block schedules conversions for a monitor with three measurement channels: bus voltage, shunt voltage and die temperature. A 4-bit mode field selects shutdown, one triggered pass, or continuous passes, over any subset of the three channels. Each channel has its own 3-bit conversion-time code, taken from an eight-entry table of microsecond windows. An 8-bit start-up delay holds off the first conversion after every restart. The delay counts in steps of `DLY_STEP_TICKS` microsecond ticks, which is 2 ms by default.

The sequencer drives a one-cycle `conv_start` strobe and a channel number to an external converter. It then counts the channel's window on the `us_tick` time base. After the window it waits for the converter's `conv_done` strobe before it moves to the next enabled channel. When the last enabled channel of a pass is finished, `cycle_done` pulses for one clock.

Settings are loaded together by `cfg_wr`. A `cfg_rst` strobe restores every setting to its power-on value. Either strobe aborts any work in progress and restarts sequencing.

The control is one state machine with these states:
- IDLE: stopped.
- ARM: decides how to start after a restart.
- DELAY: start-up wait.
- LAUNCH: start strobe.
- MEASURE: conversion window.
- AWAIT: waiting for the converter.
- WRAP: end of pass.

Its transitions are:
- Any state goes to ARM on a restart.
- ARM goes to IDLE when no channel is enabled, to LAUNCH when the delay is zero, and to DELAY otherwise.
- DELAY goes to LAUNCH when the delay has expired.
- LAUNCH goes to MEASURE.
- MEASURE goes to AWAIT when the window has expired.
- AWAIT goes to LAUNCH when done is seen and a later channel is enabled, and to WRAP when done is seen and no later channel is enabled.
- WRAP goes to LAUNCH in continuous mode and to IDLE in triggered mode.

Top module: `cseq_sequencer`

## Requirements
- R1: After `rst_n` is released, the settings are mode Fh, all three conversion-time codes 5 (1052 ticks) and delay 0. The bus channel is launched in the first cycle after release, and both strobes are low while reset is held.
- R2: Mode values 0h and 8h (bits 2:0 all zero) produce no `conv_start` and no `cycle_done`.
- R3: Mode bit 0 enables the bus channel (`conv_chan` = 0), bit 1 enables the shunt channel (`conv_chan` = 1) and bit 2 enables the temperature channel (`conv_chan` = 2). Within a pass, enabled channels launch in the order 0, 1, 2 and disabled channels are skipped.
- R4: A channel's window lasts `us_tick` pulses equal to its code's entry in the list 0:50, 1:84, 2:150, 3:280, 4:540, 5:1052, 6:2074, 7:4120, counted from the cycle after its start strobe. With a tick in every cycle and `conv_done` held high, consecutive launches are the window length plus 2 clocks apart.
- R5: Each channel uses its own code: `cfg_bus_ct` for the bus channel, `cfg_shunt_ct` for the shunt channel and `cfg_temp_ct` for the temperature channel.
- R6: After a restart, the first launch waits `cfg_delay` × `DLY_STEP_TICKS` ticks. With a tick in every cycle it appears 1 + that many clocks after the write edge. No delay is inserted between continuous passes.
- R7: With mode bit 3 = 0, one pass runs and the block then stays idle. Writing a triggered mode again runs a new pass.
- R8: With mode bit 3 = 1, passes repeat. The next pass launches one clock after `cycle_done`.
- R9: After its window a channel waits for `conv_done`, and launches the next channel in the cycle after a `conv_done` that arrives in AWAIT. A `conv_done` that arrives during the window is remembered.
- R10: `cycle_done` is one clock wide. It appears in the cycle after the last enabled channel's done is accepted, which is window + 2 clocks after that channel's launch when done is already present.
- R11: A `cfg_wr` in the middle of a pass aborts it: no `cycle_done` is produced for the aborted pass, and sequencing restarts under the new settings.
- R12: `cfg_rst` restores the R1 defaults and restarts sequencing, and it takes priority over a simultaneous `cfg_wr`.
- R13: `conv_start` is one clock wide, and windows advance only on cycles with `us_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cfg_wr | input | 1 | Loads all cfg_* fields and restarts sequencing |
| cfg_rst | input | 1 | Restores default settings and restarts sequencing |
| cfg_mode | input | 4 | Bit 3 selects continuous; bits 2:0 enable the temperature, shunt and bus channels |
| cfg_bus_ct | input | 3 | Bus channel conversion-time code |
| cfg_shunt_ct | input | 3 | Shunt channel conversion-time code |
| cfg_temp_ct | input | 3 | Temperature channel conversion-time code |
| cfg_delay | input | DLY_W | Start-up delay in steps of DLY_STEP_TICKS |
| conv_start | output | 1 | Start strobe to the converter |
| conv_chan | output | 2 | Channel being converted (0 bus, 1 shunt, 2 temperature) |
| conv_done | input | 1 | Converter finished strobe |
| cycle_done | output | 1 | One-clock pulse at the end of a pass |

## Verification
The bench builds the block with `DLY_W` = 8 and `DLY_STEP_TICKS` = 8. With this delay step, even the largest delay code (255, that is 2040 ticks) finishes within a few thousand clocks.

The bench drives `us_tick` in every cycle, so every window maps to an exact clock count. This makes it possible to sweep all sixteen modes and all eight conversion-time codes, and to compare every launch time and channel against a list computed arithmetically. One run gates the tick to every second cycle to show that windows count ticks rather than clocks. Other runs withhold `conv_done` to exercise the wait in AWAIT, and send it early to exercise the remembered done.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    localparam int NUM_CH  = 3;
    localparam int CT_W    = 3;
    localparam int MODE_W  = 4;
    localparam int CHAN_W  = 2;
    localparam int CT_TW   = 13;
    localparam int CT_MAX  = 4120;

    localparam logic [MODE_W-1:0] MODE_DEFAULT = 4'hF;
    localparam logic [CT_W-1:0]   CT_DEFAULT   = 3'd5;

    localparam logic [CHAN_W-1:0] CH_BUS   = 2'd0;
    localparam logic [CHAN_W-1:0] CH_SHUNT = 2'd1;
    localparam logic [CHAN_W-1:0] CH_TEMP  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARM     = 3'd1,
        ST_DELAY   = 3'd2,
        ST_LAUNCH  = 3'd3,
        ST_MEASURE = 3'd4,
        ST_AWAIT   = 3'd5,
        ST_WRAP    = 3'd6
    } seq_state_e;

    // Window length in microsecond ticks for a conversion-time code.
    function automatic logic [CT_TW-1:0] ct_ticks(input logic [CT_W-1:0] code);
        logic [CT_TW-1:0] t;
        unique case (code)
            3'd0:    t = 13'd50;
            3'd1:    t = 13'd84;
            3'd2:    t = 13'd150;
            3'd3:    t = 13'd280;
            3'd4:    t = 13'd540;
            3'd5:    t = 13'd1052;
            3'd6:    t = 13'd2074;
            default: t = 13'd4120;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/cseq_settings.sv
module cseq_settings
    import cseq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_rst,
    input  logic                         cfg_wr,
    input  logic [MODE_W-1:0]            mode_in,
    input  logic [NUM_CH-1:0][CT_W-1:0]  ct_in,
    input  logic [DLY_W-1:0]             dly_in,
    output logic [MODE_W-1:0]            mode_q,
    output logic [NUM_CH-1:0][CT_W-1:0]  ct_q,
    output logic [DLY_W-1:0]             dly_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_DEFAULT;
            dly_q  <= '0;
            for (int i = 0; i < NUM_CH; i++) ct_q[i] <= CT_DEFAULT;
        end else if (cfg_rst) begin
            mode_q <= MODE_DEFAULT;
            dly_q  <= '0;
            for (int i = 0; i < NUM_CH; i++) ct_q[i] <= CT_DEFAULT;
        end else if (cfg_wr) begin
            mode_q <= mode_in;
            dly_q  <= dly_in;
            for (int i = 0; i < NUM_CH; i++) ct_q[i] <= ct_in[i];
        end
    end

endmodule

// File: rtl/cseq_chan_pick.sv
module cseq_chan_pick
    import cseq_pkg::*;
(
    input  logic [NUM_CH-1:0] en,
    input  logic [CHAN_W-1:0] cur,
    output logic [CHAN_W-1:0] first_ch,
    output logic [CHAN_W-1:0] next_ch,
    output logic              has_next,
    output logic              any_en
);

    logic [NUM_CH-1:0] later;

    // Channels that are enabled and come after the current one.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_later
        assign later[g] = en[g] && (g > int'(cur));
    end

    always_comb begin
        first_ch = CH_BUS;
        next_ch  = CH_BUS;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (en[i])    first_ch = CHAN_W'(i);
            if (later[i]) next_ch  = CHAN_W'(i);
        end
        has_next = |later;
        any_en   = |en;
    end

endmodule

// File: rtl/cseq_tick_timer.sv
module cseq_tick_timer #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         hit
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    // Fires on the tick that completes the target count.
    assign hit = run && tick && (cnt_q == target - 1'b1);

endmodule

// File: rtl/cseq_sequencer.sv
module cseq_sequencer
    import cseq_pkg::*;
#(
    parameter int DLY_W          = 8,
    parameter int DLY_STEP_TICKS = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cfg_wr,
    input  logic              cfg_rst,
    input  logic [3:0]        cfg_mode,
    input  logic [2:0]        cfg_bus_ct,
    input  logic [2:0]        cfg_shunt_ct,
    input  logic [2:0]        cfg_temp_ct,
    input  logic [DLY_W-1:0]  cfg_delay,
    output logic              conv_start,
    output logic [1:0]        conv_chan,
    input  logic              conv_done,
    output logic              cycle_done
);

    localparam int DLY_MAX = ((2 ** DLY_W) - 1) * DLY_STEP_TICKS;
    localparam int TGT_MAX = (DLY_MAX > CT_MAX) ? DLY_MAX : CT_MAX;
    localparam int TMR_W   = $clog2(TGT_MAX + 1);

    logic [MODE_W-1:0]           mode_q;
    logic [NUM_CH-1:0][CT_W-1:0] ct_q;
    logic [DLY_W-1:0]            dly_q;
    logic [NUM_CH-1:0][CT_W-1:0] ct_in;

    seq_state_e        state_q, state_d;
    logic [CHAN_W-1:0] chan_q, chan_d;
    logic              done_seen_q;
    logic              restart;

    logic [CHAN_W-1:0] first_ch, next_ch;
    logic              has_next, any_en;
    logic              tmr_run, tmr_hit;
    logic [TMR_W-1:0]  tmr_tgt;
    logic [CT_W-1:0]   ct_sel;

    assign restart = cfg_wr | cfg_rst;

    assign ct_in[0] = cfg_bus_ct;
    assign ct_in[1] = cfg_shunt_ct;
    assign ct_in[2] = cfg_temp_ct;

    cseq_settings #(.DLY_W(DLY_W)) u_set (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_rst (cfg_rst),
        .cfg_wr  (cfg_wr),
        .mode_in (cfg_mode),
        .ct_in   (ct_in),
        .dly_in  (cfg_delay),
        .mode_q  (mode_q),
        .ct_q    (ct_q),
        .dly_q   (dly_q)
    );

    cseq_chan_pick u_pick (
        .en       (mode_q[NUM_CH-1:0]),
        .cur      (chan_q),
        .first_ch (first_ch),
        .next_ch  (next_ch),
        .has_next (has_next),
        .any_en   (any_en)
    );

    // Conversion-time code of the channel in flight.
    always_comb begin
        unique case (chan_q)
            CH_BUS:   ct_sel = ct_q[0];
            CH_SHUNT: ct_sel = ct_q[1];
            default:  ct_sel = ct_q[2];
        endcase
    end

    assign tmr_run = (state_q == ST_DELAY) || (state_q == ST_MEASURE);
    assign tmr_tgt = (state_q == ST_DELAY)
                   ? TMR_W'(dly_q) * TMR_W'(DLY_STEP_TICKS)
                   : TMR_W'(ct_ticks(ct_sel));

    cseq_tick_timer #(.W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .tick   (us_tick),
        .target (tmr_tgt),
        .hit    (tmr_hit)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        if (restart) begin
            state_d = ST_ARM;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ARM: begin
                    if (!any_en) begin
                        state_d = ST_IDLE;
                    end else if (dly_q == '0) begin
                        state_d = ST_LAUNCH;
                        chan_d  = first_ch;
                    end else begin
                        state_d = ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (tmr_hit) begin
                        state_d = ST_LAUNCH;
                        chan_d  = first_ch;
                    end
                end
                ST_LAUNCH: state_d = ST_MEASURE;
                ST_MEASURE: begin
                    if (tmr_hit) state_d = ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (done_seen_q || conv_done) begin
                        if (has_next) begin
                            state_d = ST_LAUNCH;
                            chan_d  = next_ch;
                        end else begin
                            state_d = ST_WRAP;
                        end
                    end
                end
                ST_WRAP: begin
                    if (mode_q[3]) begin
                        state_d = ST_LAUNCH;
                        chan_d  = first_ch;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register, channel register and early-done memory.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_ARM;
            chan_q      <= CH_BUS;
            done_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            if (restart || state_q == ST_LAUNCH)
                done_seen_q <= 1'b0;
            else if (state_q == ST_MEASURE && conv_done)
                done_seen_q <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        conv_start = (state_q == ST_LAUNCH);
        cycle_done = (state_q == ST_WRAP);
        conv_chan  = chan_q;
    end

endmodule

// File: rtl/cseq_sequencer_chk.sv
module cseq_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       cfg_rst,
    input logic       conv_start,
    input logic [1:0] conv_chan,
    input logic       cycle_done,
    input logic [3:0] mode_q
);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R13

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R10

    AST_START_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && cycle_done)); // R10

    AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != 2'd3)); // R3

    AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> mode_q[conv_chan]); // R3

    AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2:0] == 3'd0) |-> (!conv_start && !cycle_done)); // R2

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || cfg_rst) |=> (!conv_start && !cycle_done)); // R11

endmodule

bind cseq_sequencer cseq_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_rst    (cfg_rst),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .cycle_done (cycle_done),
    .mode_q     (mode_q)
);

// File: tb/tb_cseq_sequencer.sv
module tb_cseq_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int DLY_STEP   = 8;
    localparam int LOG_N      = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_rst = 1'b0;
    logic [3:0] cfg_mode = 4'h0;
    logic [2:0] cfg_bus_ct = 3'd0;
    logic [2:0] cfg_shunt_ct = 3'd0;
    logic [2:0] cfg_temp_ct = 3'd0;
    logic [7:0] cfg_delay = 8'd0;
    logic       conv_start, cycle_done;
    logic [1:0] conv_chan;
    logic       us_tick, conv_done;
    logic       tick_every = 1'b1;
    logic       tick_ph = 1'b0;
    logic       done_auto = 1'b1;
    logic       done_man = 1'b0;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int ev_t [LOG_N];
    int ev_k [LOG_N];
    int ev_n = 0;
    int ex_t [LOG_N];
    int ex_k [LOG_N];
    int ex_n = 0;
    int w;
    int x;

    assign us_tick   = tick_every | tick_ph;
    assign conv_done = done_auto | done_man;

    cseq_sequencer #(.DLY_W(8), .DLY_STEP_TICKS(DLY_STEP)) dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .cfg_wr(cfg_wr), .cfg_rst(cfg_rst), .cfg_mode(cfg_mode),
        .cfg_bus_ct(cfg_bus_ct), .cfg_shunt_ct(cfg_shunt_ct),
        .cfg_temp_ct(cfg_temp_ct), .cfg_delay(cfg_delay),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .cycle_done(cycle_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        tick_ph <= ~tick_ph;
    end

    // Event log, sampled at the falling edge: kind 0..2 = launch of a channel, 3 = end of pass.
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start && ev_n < LOG_N) begin
                ev_t[ev_n] = cyc; ev_k[ev_n] = int'(conv_chan); ev_n = ev_n + 1;
            end
            if (cycle_done && ev_n < LOG_N) begin
                ev_t[ev_n] = cyc; ev_k[ev_n] = 3; ev_n = ev_n + 1;
            end
        end
    end

    function automatic int ct_us(input int code);
        case (code)
            0: return 50;    1: return 84;    2: return 150;   3: return 280;
            4: return 540;   5: return 1052;  6: return 2074;  default: return 4120;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Expected launches: next start = start + window + 2, pass end likewise, next pass + 1.
    task automatic build_exp(input int t0, input bit [2:0] en, input int cb, input int cs,
                             input int ct, input int passes);
        int t;
        int codes [3];
        codes[0] = cb; codes[1] = cs; codes[2] = ct;
        t = t0;
        ex_n = 0;
        for (int p = 0; p < passes; p++) begin
            for (int c = 0; c < 3; c++) begin
                if (en[c]) begin
                    ex_t[ex_n] = t; ex_k[ex_n] = c; ex_n++;
                    t = t + ct_us(codes[c]) + 2;
                end
            end
            ex_t[ex_n] = t; ex_k[ex_n] = 3; ex_n++;
            t = t + 1;
        end
    endtask

    task automatic compare(input string req, input bit exact);
        if (exact) check(ev_n == ex_n, req, ev_n, ex_n);
        else       check(ev_n >= ex_n, req, ev_n, ex_n);
        for (int i = 0; i < ex_n && i < ev_n; i++)
            check(ev_t[i] == ex_t[i] && ev_k[i] == ex_k[i], req,
                  ev_t[i] * 4 + ev_k[i], ex_t[i] * 4 + ex_k[i]);
    endtask

    task automatic do_write(input bit [3:0] m, input int b, input int s, input int t,
                            input int d, input bit rs, output int wc);
        @(posedge clk); #1;
        cfg_mode = m; cfg_bus_ct = 3'(b); cfg_shunt_ct = 3'(s); cfg_temp_ct = 3'(t);
        cfg_delay = 8'(d); cfg_wr = 1'b1; cfg_rst = rs;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_rst = 1'b0;
        ev_n = 0;
        wc = cyc;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state and defaults
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(conv_start == 1'b0, "R1 start low in reset", int'(conv_start), 0);
        check(cycle_done == 1'b0, "R1 done low in reset", int'(cycle_done), 0);
        @(posedge clk); #1;
        rst_n = 1'b1; ev_n = 0; w = cyc;
        build_exp(w + 1, 3'b111, 5, 5, 5, 1);
        wait_until(ex_t[ex_n - 1] + 2);
        compare("R1 default pass", 1'b0);

        // R2 R3 R7 R8: sweep all modes, codes 0/1/2 on bus/shunt/temp
        for (int m = 0; m < 16; m++) begin
            do_write(4'(m), 0, 1, 2, 0, 1'b0, w);
            if ((m & 7) == 0) begin
                wait_until(w + 400);
                check(ev_n == 0, "R2 shutdown quiet", ev_n, 0);
            end else begin
                build_exp(w + 1, 3'(m & 7), 0, 1, 2, (m >= 8) ? 2 : 1);
                wait_until(ex_t[ex_n - 1] + ((m >= 8) ? 1 : 60));
                if (m >= 8) compare("R3 R8 continuous sweep", 1'b0);
                else        compare("R3 R7 triggered sweep", 1'b1);
            end
        end

        // R4: every conversion-time code on the bus channel
        for (int c = 0; c < 8; c++) begin
            do_write(4'h1, c, 0, 0, 0, 1'b0, w);
            build_exp(w + 1, 3'b001, c, 0, 0, 1);
            wait_until(ex_t[ex_n - 1] + 20);
            compare("R4 window table", 1'b1);
        end

        // R5: distinct codes per channel
        do_write(4'h7, 3, 0, 6, 0, 1'b0, w);
        build_exp(w + 1, 3'b111, 3, 0, 6, 1);
        wait_until(ex_t[ex_n - 1] + 20);
        compare("R5 per-channel codes", 1'b1);
        do_write(4'h6, 7, 4, 1, 0, 1'b0, w);
        build_exp(w + 1, 3'b110, 7, 4, 1, 1);
        wait_until(ex_t[ex_n - 1] + 20);
        compare("R5 per-channel codes shunt temp", 1'b1);

        // R6: start-up delay
        do_write(4'h5, 0, 0, 0, 3, 1'b0, w);
        build_exp(w + 1 + 3 * DLY_STEP, 3'b101, 0, 0, 0, 1);
        wait_until(ex_t[ex_n - 1] + 20);
        compare("R6 delay triggered", 1'b1);
        do_write(4'h9, 0, 0, 0, 2, 1'b0, w);
        build_exp(w + 1 + 2 * DLY_STEP, 3'b001, 0, 0, 0, 3);
        wait_until(ex_t[ex_n - 1] + 1);
        compare("R6 R8 no delay between passes", 1'b0);
        do_write(4'h1, 0, 0, 0, 255, 1'b0, w);
        build_exp(w + 1 + 255 * DLY_STEP, 3'b001, 0, 0, 0, 1);
        wait_until(ex_t[ex_n - 1] + 20);
        compare("R6 largest delay", 1'b1);

        // R7: triggered pass stays idle, rewrite runs again
        do_write(4'h4, 0, 0, 0, 0, 1'b0, w);
        build_exp(w + 1, 3'b100, 0, 0, 0, 1);
        wait_until(ex_t[ex_n - 1] + 500);
        compare("R7 one pass then idle", 1'b1);
        do_write(4'h4, 0, 0, 0, 0, 1'b0, w);
        build_exp(w + 1, 3'b100, 0, 0, 0, 1);
        wait_until(ex_t[ex_n - 1] + 100);
        compare("R7 retrigger", 1'b1);

        // R9 R10: converter handshake
        done_auto = 1'b0;
        do_write(4'h3, 0, 0, 0, 0, 1'b0, w);
        wait_until(w + 120);
        check(ev_n == 1, "R9 waits for done", ev_n, 1);
        check(ev_t[0] == w + 1 && ev_k[0] == 0, "R9 bus launch", ev_t[0], w + 1);
        @(posedge clk); #1;
        done_man = 1'b1; x = cyc;
        @(posedge clk); #1;
        done_man = 1'b0;
        wait_until(x + 4);
        check(ev_n == 2, "R9 advance on done", ev_n, 2);
        check(ev_t[1] == x + 1 && ev_k[1] == 1, "R9 shunt launch after done", ev_t[1], x + 1);
        @(posedge clk); #1;
        done_man = 1'b1;
        @(posedge clk); #1;
        done_man = 1'b0;
        wait_until(x + 1 + 52 + 30);
        check(ev_n == 3, "R9 early done remembered", ev_n, 3);
        check(ev_t[2] == x + 1 + 52 && ev_k[2] == 3, "R10 pass end timing", ev_t[2], x + 53);
        done_auto = 1'b1;

        // R11: abort mid-pass
        do_write(4'hF, 2, 2, 2, 0, 1'b0, w);
        wait_until(w + 100);
        do_write(4'h2, 0, 1, 0, 0, 1'b0, w);
        build_exp(w + 1, 3'b010, 0, 1, 0, 1);
        wait_until(ex_t[ex_n - 1] + 200);
        compare("R11 abort and restart", 1'b1);

        // R12: settings reset strobe wins over write
        do_write(4'h1, 0, 0, 0, 5, 1'b0, w);
        do_write(4'h2, 0, 0, 0, 9, 1'b1, w);
        build_exp(w + 1, 3'b111, 5, 5, 5, 1);
        wait_until(ex_t[ex_n - 1] + 2);
        compare("R12 defaults restored", 1'b0);

        // R13: windows count ticks, not clocks
        tick_every = 1'b0;
        do_write(4'h1, 1, 0, 0, 0, 1'b0, w);
        wait_until(w + 250);
        check(ev_n == 2, "R13 gated tick events", ev_n, 2);
        check(ev_t[0] == w + 1, "R13 launch time", ev_t[0], w + 1);
        check((ev_t[1] - ev_t[0]) == 169 || (ev_t[1] - ev_t[0]) == 170,
              "R13 gated window", ev_t[1] - ev_t[0], 169);
        tick_every = 1'b1;

        finished = 1;
        summary();
        $finish;
    end

endmodule